// File: doc/BRIEF.md
# CRC-Protected I2C Register Target

This block is the bus-facing side of a small register file. It listens on a two-wire open-drain bus. SCL is only ever read. SDA is split into a sampled input and an active-high pull-low enable. The block answers to one fixed 7-bit address. Every transfer carries a CRC-8 check byte (polynomial 0x07, initial value 0x00, MSB first, no reflection, no final XOR). The CRC is computed over the bytes exactly as they appear on the wire, and that includes the address byte with its direction bit.

A host writes one register with a four-byte frame: the address byte, the register index, the data byte and a check byte. The register strobe fires only when the check byte matches. A mismatch still completes the bus handshake, but the file is left untouched and a sticky error flag is raised. To read, the host first writes just the register index, which sets the pointer. It then issues a repeated start with the read address. The target returns the addressed byte followed by a check byte computed over the read address byte and that data byte. After the host NACKs, the target lets go of the bus until the next start or stop.

Top module: `crc_i2c_target`

## Requirements
- R1: After reset, sda_oe, reg_we and crc_error are all 0.
- R2: Only address byte 0x10 (write) or 0x11 (read), i.e. 7-bit address 0x08 plus the direction bit in bit 0, is acknowledged. Any other address byte gets no ACK, and the rest of that transfer has no effect.
- R3: A write frame whose fourth byte equals CRC-8 over its first three bytes raises reg_we for exactly one clock, with reg_addr set to the second byte and reg_wdata set to the third. For example, 0x10, 0x0B, 0x19 carries check byte 0x7A.
- R4: A write frame with a wrong check byte is ACKed on every byte but produces no reg_we. It sets crc_error, which stays 1 until reset, and later good writes still commit.
- R5: After a pointer write and a repeated start with 0x11, the target sends reg_rdata at the pointer, MSB first, then CRC-8 over 0x11 and that byte. Data 0x19 gives 0x0D, and data 0x2C gives 0x86.
- R6: Once the host NACKs the check byte of a read, the target keeps sda_oe at 0 until the next start or stop, so further clocked bits read as 1.
- R7: A start or stop that arrives inside a byte abandons the transfer. No reg_we is issued, and reg_addr keeps the value it had before.
- R8: sda_oe changes only while SCL is low.
- R9: A fifth byte after a complete write frame is not acknowledged and causes no extra write.
- R10: A write of only the address byte and the register index updates reg_addr to the index without issuing reg_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 8 | Register pointer toward the register file |
| reg_wdata | output | 8 | Data byte for a committed write |
| reg_we | output | 1 | One-clock write strobe |
| reg_rdata | input | 8 | Register file contents at reg_addr |
| crc_error | output | 1 | Sticky flag: a write check byte mismatched |

## Verification
The bound checker watches, on every clock, that the write strobe is a single-cycle pulse raised while SCL is high, and that the error flag is sticky and never rises together with a strobe. It also checks that SDA drive only toggles with SCL low and that reset clears the outputs. Whether the check byte is actually correct, whether the right address and data reach the file, which bytes are ACKed, and whether aborted or unaddressed frames leave the pointer alone can only be shown by the bench's bus scenarios, which compare against CRC values the bench computes itself.

// File: rtl/crc_i2c_target.sv
module crc_i2c_target #(
  parameter logic [6:0] DEV_ADDR = 7'h08,
  parameter logic [7:0] POLY     = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata,
  output logic       crc_error
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++)
      x = x[7] ? ((x << 1) ^ POLY) : (x << 1);
    return x;
  endfunction

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  wire        scl_s = scl_sy[1];
  wire        sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;

  st_t        st;
  logic [2:0] bitcnt, idx;
  logic [7:0] sh, txsh, crc, dat, ptr;
  logic       done, ack_q, rd, tx_crc, hack;

  wire [7:0] rxb = {sh[6:0], sda_s};

  assign reg_addr  = ptr;
  assign reg_wdata = dat;
  assign sda_oe    = (st == S_RACK) | ((st == S_TX) & ~txsh[7]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      idx       <= '0;
      sh        <= '0;
      txsh      <= 8'hFF;
      crc       <= '0;
      dat       <= '0;
      ptr       <= '0;
      done      <= 1'b0;
      ack_q     <= 1'b0;
      rd        <= 1'b0;
      tx_crc    <= 1'b0;
      hack      <= 1'b0;
      reg_we    <= 1'b0;
      crc_error <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (start_c) begin
        st     <= S_RX;
        bitcnt <= '0;
        idx    <= '0;
        crc    <= '0;
        done   <= 1'b0;
      end else if (stop_c) begin
        st   <= S_IDLE;
        done <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (rise && !done) begin
              sh     <= rxb;
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                done  <= 1'b1;
                ack_q <= 1'b1;
                if (idx != 3'd7) idx <= idx + 3'd1;
                case (idx)
                  3'd0: begin
                    if (rxb[7:1] == DEV_ADDR) begin
                      rd  <= rxb[0];
                      crc <= crc_step(crc, rxb);
                    end else begin
                      ack_q <= 1'b0;
                    end
                  end
                  3'd1: begin
                    ptr <= rxb;
                    crc <= crc_step(crc, rxb);
                  end
                  3'd2: begin
                    dat <= rxb;
                    crc <= crc_step(crc, rxb);
                  end
                  3'd3: begin
                    if (rxb == crc) reg_we    <= 1'b1;
                    else            crc_error <= 1'b1;
                  end
                  default: ack_q <= 1'b0;
                endcase
              end
            end else if (fall && done) begin
              done   <= 1'b0;
              bitcnt <= '0;
              st     <= ack_q ? S_RACK : S_IDLE;
            end
          end
          S_RACK: begin
            if (fall) begin
              bitcnt <= '0;
              if (idx == 3'd1 && rd) begin
                st     <= S_TX;
                txsh   <= reg_rdata;
                crc    <= crc_step(crc, reg_rdata);
                tx_crc <= 1'b0;
              end else begin
                st <= S_RX;
              end
            end
          end
          S_TX: begin
            if (fall) begin
              if (bitcnt == 3'd7) begin
                st     <= S_TACK;
                bitcnt <= '0;
                txsh   <= 8'hFF;
              end else begin
                txsh   <= {txsh[6:0], 1'b1};
                bitcnt <= bitcnt + 3'd1;
              end
            end
          end
          S_TACK: begin
            if (rise) hack <= ~sda_s;
            if (fall) begin
              if (hack && !tx_crc) begin
                st     <= S_TX;
                txsh   <= crc;
                tx_crc <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end

endmodule

// File: rtl/crc_i2c_target_chk.sv
module crc_i2c_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic reg_we,
  input logic crc_error
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && !reg_we && !crc_error));

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r3_strobe_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> scl_i);

  a_r4_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error |=> crc_error);

  a_r4_no_strobe_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_error) |-> !reg_we);

  a_r8_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

endmodule

bind crc_i2c_target crc_i2c_target_chk u_chk (.*);

// File: tb/sim_crc_i2c_target.sv
module sim_crc_i2c_target;
  localparam int H = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_h = 1'b1;
  logic       sda_h = 1'b1;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, crc_error;
  wire        sda_line = sda_h & ~sda_oe;

  int errors = 0;
  int checks = 0;
  int we_cnt = 0;
  logic [7:0] last_a = '0, last_d = '0;
  logic [7:0] mem [256];

  always #10 clk = ~clk;

  crc_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .crc_error(crc_error)
  );

  assign reg_rdata = mem[reg_addr];

  always @(negedge clk)
    if (reg_we) begin
      we_cnt++;
      last_a = reg_addr;
      last_d = reg_wdata;
      mem[reg_addr] = reg_wdata;
    end

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = r[7] ^ b[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; w(H); scl_h = 1'b1; w(H); sda_h = 1'b0; w(H); scl_h = 1'b0; w(H);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; w(H); scl_h = 1'b1; w(H); sda_h = 1'b1; w(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; w(H); scl_h = 1'b1; w(2 * H); scl_h = 1'b0; w(H);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_h = 1'b1; w(H); scl_h = 1'b1; w(H);
    ack = ~sda_line;
    w(H); scl_h = 1'b0; w(H);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(H); scl_h = 1'b1; w(H); b[i] = sda_line; w(H); scl_h = 1'b0; w(H);
    end
    sda_h = ~ack; w(H); scl_h = 1'b1; w(2 * H); scl_h = 1'b0; w(H); sda_h = 1'b1;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(reg_we == 1'b0, "R1 reg_we", reg_we, 0);
    chk(crc_error == 1'b0, "R1 crc_error", crc_error, 0);
  endtask

  task automatic do_write(input logic [7:0] ra, input logic [7:0] d, input bit bad, output bit a0, output bit a1, output bit a2, output bit a3);
    logic [7:0] c;
    c = ref_crc(ref_crc(ref_crc(8'h00, 8'h10), ra), d);
    if (bad) c = c ^ 8'h01;
    bus_start();
    send_byte(8'h10, a0); send_byte(ra, a1); send_byte(d, a2); send_byte(c, a3);
    bus_stop();
  endtask

  task automatic t_write_good();
    bit a0, a1, a2, a3;
    int n0;
    n0 = we_cnt;
    chk(ref_crc(ref_crc(ref_crc(8'h00, 8'h10), 8'h0B), 8'h19) == 8'h7A, "R3 bench crc vector", 0, 8'h7A);
    do_write(8'h0B, 8'h19, 1'b0, a0, a1, a2, a3);
    chk(a0 && a1 && a2 && a3, "R2 write frame acks", {a0, a1, a2, a3}, 4'hF);
    chk(we_cnt == n0 + 1, "R3 one strobe", we_cnt - n0, 1);
    chk(last_a == 8'h0B, "R3 reg_addr", last_a, 8'h0B);
    chk(last_d == 8'h19, "R3 reg_wdata", last_d, 8'h19);
    chk(crc_error == 1'b0, "R3 no error", crc_error, 0);
  endtask

  task automatic t_wrong_addr();
    bit a;
    int n0;
    logic [7:0] p0;
    n0 = we_cnt; p0 = reg_addr;
    bus_start();
    send_byte(8'h12, a);
    chk(!a, "R2 foreign address nacked", a, 0);
    send_byte(8'h44, a); send_byte(8'h55, a); send_byte(8'h66, a);
    bus_stop();
    chk(we_cnt == n0, "R2 foreign no write", we_cnt - n0, 0);
    chk(reg_addr == p0, "R2 foreign pointer kept", reg_addr, p0);
  endtask

  task automatic t_bad_crc();
    bit a0, a1, a2, a3;
    int n0;
    n0 = we_cnt;
    do_write(8'h0C, 8'h55, 1'b1, a0, a1, a2, a3);
    chk(a0 && a1 && a2 && a3, "R4 bad frame still acked", {a0, a1, a2, a3}, 4'hF);
    chk(we_cnt == n0, "R4 no strobe", we_cnt - n0, 0);
    chk(crc_error == 1'b1, "R4 error set", crc_error, 1);
    chk(mem[8'h0C] == 8'h00, "R4 register unchanged", mem[8'h0C], 0);
    do_write(8'h0D, 8'hA5, 1'b0, a0, a1, a2, a3);
    chk(we_cnt == n0 + 1 && last_d == 8'hA5, "R4 later write commits", last_d, 8'hA5);
    chk(crc_error == 1'b1, "R4 error sticky", crc_error, 1);
  endtask

  task automatic t_read(input logic [7:0] ra, input logic [7:0] exp_crc, input string tag);
    bit a;
    int n0;
    logic [7:0] d, c, x;
    n0 = we_cnt;
    bus_start();
    send_byte(8'h10, a); send_byte(ra, a);
    chk(reg_addr == ra, "R10 pointer set", reg_addr, ra);
    bus_start();
    send_byte(8'h11, a);
    chk(a, "R2 read address acked", a, 1);
    recv_byte(1'b1, d);
    recv_byte(1'b0, c);
    chk(d == mem[ra], {"R5 data ", tag}, d, mem[ra]);
    chk(c == exp_crc && c == ref_crc(ref_crc(8'h00, 8'h11), d), {"R5 crc ", tag}, c, exp_crc);
    chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
    recv_byte(1'b0, x);
    chk(x == 8'hFF, "R6 bus idle after nack", x, 8'hFF);
    bus_stop();
    chk(we_cnt == n0, "R10 pointer write no strobe", we_cnt - n0, 0);
  endtask

  task automatic t_extra_byte();
    bit a;
    int n0;
    logic [7:0] c;
    n0 = we_cnt;
    c = ref_crc(ref_crc(ref_crc(8'h00, 8'h10), 8'h20), 8'h3C);
    bus_start();
    send_byte(8'h10, a); send_byte(8'h20, a); send_byte(8'h3C, a); send_byte(c, a);
    send_byte(8'h77, a);
    chk(!a, "R9 fifth byte nacked", a, 0);
    bus_stop();
    chk(we_cnt == n0 + 1, "R9 one write only", we_cnt - n0, 1);
    chk(mem[8'h20] == 8'h3C, "R9 value kept", mem[8'h20], 8'h3C);
  endtask

  task automatic t_abort();
    bit a;
    int n0;
    logic [7:0] c;
    n0 = we_cnt;
    bus_start();
    send_byte(8'h10, a); send_byte(8'h22, a);
    send_bits(8'hF0, 4);
    bus_stop();
    chk(we_cnt == n0, "R7 stop in data no write", we_cnt - n0, 0);
    chk(reg_addr == 8'h22, "R10 pointer from index", reg_addr, 8'h22);
    bus_start();
    send_byte(8'h10, a);
    send_bits(8'hFF, 5);
    bus_stop();
    chk(reg_addr == 8'h22, "R7 stop in index keeps pointer", reg_addr, 8'h22);
    c = ref_crc(ref_crc(ref_crc(8'h00, 8'h10), 8'h40), 8'h12);
    bus_start();
    send_byte(8'h10, a); send_byte(8'h40, a); send_byte(8'h12, a);
    send_bits(c, 3);
    bus_start();
    bus_stop();
    chk(we_cnt == n0, "R7 start in crc no write", we_cnt - n0, 0);
    chk(mem[8'h40] == 8'h00, "R7 register untouched", mem[8'h40], 0);
    bus_start();
    send_byte(8'h10, a);
    send_bits(8'h99, 6);
    bus_start();
    bus_stop();
    chk(reg_addr == 8'h40, "R7 start in index keeps pointer", reg_addr, 8'h40);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h51] = 8'h2C;
    w(5);
    t_reset();
    rst_n = 1'b1;
    w(5);
    t_write_good();
    t_wrong_addr();
    t_read(8'h0B, 8'h0D, "0x19");
    t_read(8'h51, 8'h86, "0x2C");
    t_bad_crc();
    t_extra_byte();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule